// File: doc/BRIEF.md
# Volatile Serial Key Loader and Lock

This block holds the key that unlocks a protected datapath and keeps that path scrambled until a key has been loaded. The key enters one bit per cycle on a dedicated serial input. Alternatively, a boot sequencer fetches the key word by word from an external non-volatile memory over a simple ready/valid port. A strap input chooses the source. The key lives only in a flip-flop shift chain. Every reset clears it, so it must be loaded again after each restart.

Once the chain has received exactly `KEY_W` bits, the key is marked loaded and is presented in parallel. A check value is folded from the key and compared with a stored constant. Only a matching key puts the block in functional mode, where the protected bus passes straight through. Until then the bus output carries a bit-reversed, masked copy of the input, so it shows neither the input nor a constant zero.

Top module: `key_lock_top`

## Requirements
- R1: While reset is asserted and right after it is released, `key_o` is all zero, `key_loaded_o` and `functional_o` are 0, and `req_valid_o` is 0.
- R2: With `boot_mode_i` low, a clock edge where both `key_valid_i` and `key_clk_en_i` are high shifts `key_o` left by one place and puts `key_bit_i` in bit 0, so the key is sent most significant bit first. If either qualifier is low, `key_o` holds its value.
- R3: `key_loaded_o` rises in the cycle after exactly `KEY_W` bits have been accepted and stays high until reset.
- R4: Bits offered after the chain is full (serial bits or memory words) leave `key_o` unchanged.
- R5: `functional_o` is 1 only when the key is loaded and its check equals `EXPECT_CHK`. The check starts at h=0 and, for chunk i = `key[i*CHK_W +: CHK_W]` with i counting up from 0, sets h = rotate-left(h,3) XOR chunk.
- R6: While `functional_o` is 0, bit i of `bus_o` equals `bus_i[BUS_W-1-i]` XOR `key_o[i]` XOR `SEED[i]`.
- R7: While `functional_o` is 1, `bus_o` equals `bus_i`.
- R8: With `boot_mode_i` high, the sequencer requests addresses 0 through `KEY_W/WORD_W-1` in order, one at a time. It holds `req_valid_o` and `req_addr_o` until `req_ready_i`, and issues the next request only after `rsp_valid_i` returns the word. Each word is shifted in as a whole, so the word at address 0 ends up as the most significant word of the key.
- R9: With `boot_mode_i` high, the serial inputs have no effect on `key_o`. With it low, `req_valid_o` stays 0.
- R10: A reset after a complete load clears `key_o` and the loaded and functional flags, and the bus goes back to being scrambled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_mode_i | input | 1 | Strap: 1 = fetch key from memory, 0 = serial key input |
| key_bit_i | input | 1 | Serial key bit |
| key_valid_i | input | 1 | Serial bit strobe |
| key_clk_en_i | input | 1 | Serial shift enable |
| req_valid_o | output | 1 | Memory read request valid |
| req_ready_i | input | 1 | Memory accepts request |
| req_addr_o | output | BOOT_AW | Word address of request |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | WORD_W | Read data word |
| bus_i | input | BUS_W | Protected bus input |
| bus_o | output | BUS_W | Protected bus output, scrambled while locked |
| key_o | output | KEY_W | Parallel key |
| key_loaded_o | output | 1 | Chain holds a full key |
| functional_o | output | 1 | Correct key loaded, bus in clear |

## Verification
The bench targets the boundary between `KEY_W-1` and `KEY_W` accepted bits. A counter that is off by one would raise the loaded flag one bit early or late, and the key would then show up shifted by one place. It shifts extra bits after a full load and checks that a chain which keeps shifting loses the key. It loads a key that is complete but wrong and checks that the bus stays scrambled, since a lock that only waited for completion would open. In boot mode it stalls the memory and drives serial bits at the same time, which exposes any leak from the serial path and any request that does not wait for ready. It then checks the word order, because a reversed address order yields a wrong key that leaves the block locked.

// File: rtl/kl_pkg.sv
package kl_pkg;
  typedef enum logic [1:0] {
    BOOT_IDLE,
    BOOT_REQ,
    BOOT_WAIT,
    BOOT_DONE
  } boot_state_e;
endpackage

// File: rtl/key_shift_chain.sv
module key_shift_chain #(
  parameter int KEY_W  = 32,
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_en_i,
  input  logic              ser_bit_i,
  input  logic              word_en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [KEY_W-1:0]  key_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(KEY_W + 1);

  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o = (cnt_q == CNT_W'(KEY_W));
  assign key_o  = key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      cnt_q <= '0;
    end else if (!full_o) begin
      if (word_en_i) begin
        key_q <= {key_q[KEY_W-WORD_W-1:0], word_i};
        cnt_q <= cnt_q + CNT_W'(WORD_W);
      end else if (ser_en_i) begin
        key_q <= {key_q[KEY_W-2:0], ser_bit_i};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/key_boot_loader.sv
module key_boot_loader
  import kl_pkg::*;
#(
  parameter int NWORDS  = 4,
  parameter int WORD_W  = 8,
  parameter int BOOT_AW = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               chain_full_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [BOOT_AW-1:0] req_addr_o,
  input  logic               rsp_valid_i,
  input  logic [WORD_W-1:0]  rsp_data_i,
  output logic               word_en_o,
  output logic [WORD_W-1:0]  word_o
);
  boot_state_e       state_q, state_d;
  logic [BOOT_AW-1:0] addr_q, addr_d;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    word_en_o = 1'b0;
    unique case (state_q)
      BOOT_IDLE: if (enable_i && !chain_full_i) state_d = BOOT_REQ;
      BOOT_REQ:  if (req_ready_i) state_d = BOOT_WAIT;
      BOOT_WAIT: if (rsp_valid_i) begin
        word_en_o = 1'b1;
        if (addr_q == BOOT_AW'(NWORDS - 1)) state_d = BOOT_DONE;
        else begin
          addr_d  = addr_q + 1'b1;
          state_d = BOOT_REQ;
        end
      end
      default: state_d = BOOT_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BOOT_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign req_valid_o = (state_q == BOOT_REQ);
  assign req_addr_o  = addr_q;
  assign word_o      = rsp_data_i;
endmodule

// File: rtl/key_lock_gate.sv
module key_lock_gate #(
  parameter int              KEY_W      = 32,
  parameter int              BUS_W      = 16,
  parameter int              CHK_W      = 16,
  parameter logic [CHK_W-1:0] EXPECT_CHK = 16'h517E,
  parameter logic [BUS_W-1:0] SEED       = 16'h5A3C
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic             loaded_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic             functional_o,
  output logic [BUS_W-1:0] bus_o
);
  localparam int NCH = KEY_W / CHK_W;

  logic [CHK_W-1:0] chk;
  logic [BUS_W-1:0] rev;

  always_comb begin
    chk = '0;
    for (int i = 0; i < NCH; i++)
      chk = {chk[CHK_W-4:0], chk[CHK_W-1:CHK_W-3]} ^ key_i[i*CHK_W +: CHK_W];
  end

  for (genvar g = 0; g < BUS_W; g++) begin : g_rev
    assign rev[g] = bus_i[BUS_W-1-g];
  end

  assign functional_o = loaded_i && (chk == EXPECT_CHK);
  assign bus_o = functional_o ? bus_i : (rev ^ key_i[BUS_W-1:0] ^ SEED);
endmodule

// File: rtl/key_lock_top.sv
module key_lock_top #(
  parameter int               KEY_W      = 32,
  parameter int               WORD_W     = 8,
  parameter int               BUS_W      = 16,
  parameter int               CHK_W      = 16,
  parameter logic [CHK_W-1:0] EXPECT_CHK = 16'h517E,
  parameter logic [BUS_W-1:0] SEED       = 16'h5A3C,
  parameter int               BOOT_AW    = (KEY_W / WORD_W > 1) ? $clog2(KEY_W / WORD_W) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boot_mode_i,
  input  logic               key_bit_i,
  input  logic               key_valid_i,
  input  logic               key_clk_en_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [BOOT_AW-1:0] req_addr_o,
  input  logic               rsp_valid_i,
  input  logic [WORD_W-1:0]  rsp_data_i,
  input  logic [BUS_W-1:0]   bus_i,
  output logic [BUS_W-1:0]   bus_o,
  output logic [KEY_W-1:0]   key_o,
  output logic               key_loaded_o,
  output logic               functional_o
);
  localparam int NWORDS = KEY_W / WORD_W;

  logic              ser_en, word_en, full;
  logic [WORD_W-1:0] word;

  assign ser_en = key_valid_i & key_clk_en_i & ~boot_mode_i;

  key_shift_chain #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_en_i  (ser_en),
    .ser_bit_i (key_bit_i),
    .word_en_i (word_en),
    .word_i    (word),
    .key_o     (key_o),
    .full_o    (full)
  );

  key_boot_loader #(.NWORDS(NWORDS), .WORD_W(WORD_W), .BOOT_AW(BOOT_AW)) u_boot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (boot_mode_i),
    .chain_full_i (full),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .req_addr_o   (req_addr_o),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_data_i   (rsp_data_i),
    .word_en_o    (word_en),
    .word_o       (word)
  );

  key_lock_gate #(
    .KEY_W(KEY_W), .BUS_W(BUS_W), .CHK_W(CHK_W),
    .EXPECT_CHK(EXPECT_CHK), .SEED(SEED)
  ) u_gate (
    .key_i        (key_o),
    .loaded_i     (full),
    .bus_i        (bus_i),
    .functional_o (functional_o),
    .bus_o        (bus_o)
  );

  assign key_loaded_o = full;
endmodule

// File: rtl/key_lock_checker.sv
module key_lock_checker #(
  parameter int KEY_W   = 32,
  parameter int BUS_W   = 16,
  parameter int BOOT_AW = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               boot_mode_i,
  input logic               req_valid_o,
  input logic               req_ready_i,
  input logic [BOOT_AW-1:0] req_addr_o,
  input logic [BUS_W-1:0]   bus_i,
  input logic [BUS_W-1:0]   bus_o,
  input logic [KEY_W-1:0]   key_o,
  input logic               key_loaded_o,
  input logic               functional_o
);
  a_r3_loaded_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(key_loaded_o));
  a_r4_key_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_loaded_o |=> $stable(key_o));
  a_r5_func_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    functional_o |-> key_loaded_o);
  a_r7_clear_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    functional_o |-> (bus_o == bus_i));
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));
  a_r9_no_req_serial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_mode_i |-> !req_valid_o);
endmodule

bind key_lock_top key_lock_checker #(.KEY_W(KEY_W), .BUS_W(BUS_W), .BOOT_AW(BOOT_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .boot_mode_i  (boot_mode_i),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_addr_o   (req_addr_o),
  .bus_i        (bus_i),
  .bus_o        (bus_o),
  .key_o        (key_o),
  .key_loaded_o (key_loaded_o),
  .functional_o (functional_o)
);

// File: tb/key_lock_top_tb.sv
module key_lock_top_tb;
  localparam int KEY_W = 32, WORD_W = 8, BUS_W = 16, CHK_W = 16, AW = 2;
  localparam int NW = KEY_W / WORD_W;
  localparam logic [KEY_W-1:0] GOOD = 32'hC0DE_1234;
  localparam logic [KEY_W-1:0] BAD  = 32'h0000_0001;
  localparam logic [BUS_W-1:0] SEED = 16'h5A3C;

  function automatic logic [CHK_W-1:0] fold(input logic [KEY_W-1:0] k);
    logic [CHK_W-1:0] h = '0;
    for (int i = 0; i < KEY_W / CHK_W; i++) begin
      h = (h << 3) | (h >> (CHK_W - 3));
      h = h ^ k[i*CHK_W +: CHK_W];
    end
    return h;
  endfunction

  localparam logic [CHK_W-1:0] EXP = fold(GOOD);

  localparam logic [BUS_W-1:0] VEC [8] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h1234,
                                           16'hA5A5, 16'h0F0F, 16'h7FFE, 16'hBEEF};

  logic clk = 0, rst_n = 0;
  logic boot_mode = 0, kbit = 0, kvalid = 0, kclk_en = 0;
  logic req_valid, req_ready = 0, rsp_valid = 0;
  logic [AW-1:0] req_addr;
  logic [WORD_W-1:0] rsp_data = '0;
  logic [BUS_W-1:0] bus_in = '0, bus_out;
  logic [KEY_W-1:0] key;
  logic loaded, func;
  int checks = 0, fails = 0;
  bit mem_on = 0, pend = 0;
  int exp_addr = 0;

  always #2.5 clk = ~clk;

  key_lock_top #(.EXPECT_CHK(EXP), .SEED(SEED)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .boot_mode_i(boot_mode), .key_bit_i(kbit),
    .key_valid_i(kvalid), .key_clk_en_i(kclk_en), .req_valid_o(req_valid),
    .req_ready_i(req_ready), .req_addr_o(req_addr), .rsp_valid_i(rsp_valid),
    .rsp_data_i(rsp_data), .bus_i(bus_in), .bus_o(bus_out), .key_o(key),
    .key_loaded_o(loaded), .functional_o(func)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] scr(input logic [BUS_W-1:0] d, input logic [KEY_W-1:0] k);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < BUS_W; i++) r[i] = d[BUS_W-1-i];
    return r ^ k[BUS_W-1:0] ^ SEED;
  endfunction

  task automatic shift(input logic b, input logic v, input logic e);
    @(negedge clk); kbit = b; kvalid = v; kclk_en = e;
    @(negedge clk); kvalid = 0; kclk_en = 0;
  endtask

  task automatic walk(input string rq, input bit clear, input logic [KEY_W-1:0] k);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bus_in = VEC[i]; #1;
      chk(rq, bus_out, clear ? VEC[i] : scr(VEC[i], k));
    end
  endtask

  task automatic do_reset(input logic bm);
    @(negedge clk); rst_n = 0; boot_mode = bm;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  // memory model: one cycle response after handshake, ready toggles
  always @(negedge clk) begin
    rsp_valid = 0;
    if (!mem_on) req_ready = 0;
    else begin
      if (pend) begin
        rsp_valid = 1;
        rsp_data  = GOOD[(NW-1-exp_addr)*WORD_W +: WORD_W];
        pend = 0; exp_addr++;
      end
      req_ready = ~req_ready;
      if (req_valid && req_ready) begin
        chk("R8 addr order", 64'(req_addr), 64'(exp_addr));
        pend = 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 key in reset", 64'(key), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags", {loaded, func, req_valid}, 0);
    walk("R6 locked zero key", 0, '0);

    // qualifiers: each alone must not shift
    shift(1, 1, 0); shift(1, 0, 1);
    chk("R2 no shift w/o both qualifiers", 64'(key), 0);

    for (int i = KEY_W-1; i >= 1; i--) shift(GOOD[i], 1, 1);
    chk("R2 partial key msb first", 64'(key), 64'(GOOD >> 1));
    chk("R3 not loaded at KEY_W-1", 64'(loaded), 0);
    shift(GOOD[0], 1, 1);
    chk("R3 loaded at KEY_W", 64'(loaded), 1);
    chk("R2 full key", 64'(key), 64'(GOOD));
    chk("R5 functional good key", 64'(func), 1);
    chk("R9 no request in serial mode", 64'(req_valid), 0);
    walk("R7 clear path", 1, GOOD);

    for (int i = 0; i < 5; i++) shift(~GOOD[i], 1, 1);
    chk("R4 extra bits ignored", 64'(key), 64'(GOOD));
    chk("R3 loaded stays", 64'(loaded), 1);

    do_reset(0);
    chk("R10 key cleared", {65'(key), loaded, func} == 0 ? 64'd0 : 64'd1, 0);
    walk("R10 relocked", 0, '0);

    for (int i = KEY_W-1; i >= 0; i--) shift(BAD[i], 1, 1);
    chk("R5 wrong key loaded", 64'(loaded), 1);
    chk("R5 wrong key not functional", 64'(func), 0);
    walk("R6 locked wrong key", 0, BAD);

    // boot mode with stalled memory
    do_reset(1);
    @(negedge clk);
    for (int i = 0; i < 6; i++) shift(1, 1, 1);
    chk("R9 serial ignored in boot mode", 64'(key), 0);
    chk("R8 request pending", {62'(0), req_valid, req_addr == 0}, 64'd3);
    mem_on = 1;
    for (int i = 0; i < 200 && !loaded; i++) @(negedge clk);
    @(negedge clk);
    chk("R8 boot key order", 64'(key), 64'(GOOD));
    chk("R8 words fetched", 64'(exp_addr), 64'(NW));
    chk("R5 boot functional", 64'(func), 1);
    repeat (4) @(negedge clk);
    chk("R8 no request after load", 64'(req_valid), 0);
    chk("R4 key held after boot", 64'(key), 64'(GOOD));
    mem_on = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule